// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It drives the select lines of the analog switch network through a cycle of four phases that repeats: offset nulling (autozero), integration of the input for a fixed time, reference de-integration, and discharge of the integrator (zero-integrator). While de-integrating it counts clocks until the comparator reports that the integrator has crossed back through zero. That count is the magnitude of the reading.

The comparator is seen as a single digital input. Its value on the last clock of the integrate phase is latched as the polarity. This latched value picks the reference sign used during de-integration, and it is reported alongside the count. A reading that hits full scale without a crossing is flagged as over-range, and the integrator discharge that follows runs much longer. A small reading is flagged as under-range, so that a host can switch ranges. A run input lets a host stop conversions at the end of the current cycle. A busy output shows when the input is being measured.

The states and their transitions are `PH_AZ` -> `PH_INT` (autozero time used up and run high), `PH_INT` -> `PH_DE` (fixed integrate time over, polarity latched), `PH_DE` -> `PH_ZI` (comparator crossing, or full scale reached), and `PH_ZI` -> `PH_AZ` (discharge time over). Autozero is stretched so that each cycle has a constant length.

Top module: `dsq_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) puts the sequencer in autozero (`sel_o` = 4'b0001) with the count cleared. `result_o`, `positive_o`, `over_o`, `under_o`, `strobe_o` and `busy_o` are all 0.
- R2: The phases always follow the order autozero, integrate, de-integrate, zero-integrator, then autozero again. Exactly one bit of `sel_o` is high on every clock: bit 0 autozero, bit 1 integrate, bit 2 de-integrate, bit 3 zero-integrator.
- R3: The integrate phase lasts exactly `INT_CLKS` clocks, whatever the comparator does.
- R4: The value of `cmp_i` on the last integrate clock is latched. It appears on `ref_pol_o` from the first de-integrate clock and holds until the next integrate phase ends. It also becomes `positive_o` of the reading (1 = comparator high).
- R5: De-integration ends on the first clock on which `cmp_i` differs from the latched polarity. If that is de-integrate clock k (counting from 0), the reading is k. The new `result_o` appears, and `strobe_o` is high for exactly one clock, on the first zero-integrator clock.
- R6: If `FULL_SCALE` de-integrate clocks pass with no crossing, the reading is `FULL_SCALE` and `over_o` is 1. A normal reading clears `over_o`.
- R7: `under_o` is 1 exactly when the reading is below `UNDER_LIMIT` and not over-range.
- R8: The zero-integrator phase lasts `ZI_NORM` clocks, or `ZI_OVER` clocks after an over-range reading.
- R9: The autozero phase lasts max(`AZ_MIN`, `CYCLE_CLKS` minus the clocks the previous cycle spent outside autozero). The first autozero after reset lasts `AZ_MIN` clocks.
- R10: While `run_i` is low, the current cycle completes and the sequencer then stays in autozero, with the reading and its flags held and no strobe. Once `run_i` rises after the minimum autozero time has passed, integration starts on the next clock.
- R11: `busy_o` is high exactly on integrate and de-integrate clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | High: start new cycles; low: hold in autozero after the current cycle |
| cmp_i | input | 1 | Comparator output (integrator above zero when high) |
| sel_o | output | 4 | One-hot phase select for the analog switches |
| busy_o | output | 1 | High during integrate and de-integrate |
| ref_pol_o | output | 1 | Latched polarity, selects the reference sign |
| result_o | output | RW | Magnitude of the last reading in counts |
| positive_o | output | 1 | Sign of the last reading (1 = comparator high) |
| over_o | output | 1 | Last reading reached full scale |
| under_o | output | 1 | Last reading below the under-range limit |
| strobe_o | output | 1 | One-clock pulse when the reading updates |

## Verification
The hardest case to reach is the coupling between one cycle and the next. The length of autozero depends on how long the previous de-integrate and discharge phases ran, and a long discharge follows only an over-range reading. To get there, the bench holds the comparator at the latched level for the whole full-scale window. It then measures the stretched discharge and the shortened autozero that follow, and runs a zero-count conversion straight after to show that both return to normal. To reach the run/hold case, the bench drops the run input in the middle of an integrate phase. It then watches the cycle finish and the sequencer stay parked.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2,
        PH_ZI  = 2'd3
    } phase_e;

    function automatic phase_e phase_succ(input phase_e p);
        unique case (p)
            PH_AZ:  return PH_INT;
            PH_INT: return PH_DE;
            PH_DE:  return PH_ZI;
            PH_ZI:  return PH_AZ;
        endcase
    endfunction

endpackage

// File: rtl/dsq_phase_fsm.sv
module dsq_phase_fsm
    import dsq_pkg::*;
#(
    parameter int INT_CLKS   = 10000,
    parameter int FULL_SCALE = 20000,
    parameter int ZI_NORM    = 150,
    parameter int ZI_OVER    = 6200,
    parameter int CW         = 16,
    parameter int RW         = 15
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic          cmp_i,
    input  logic [CW-1:0] az_len_i,
    output phase_e        phase_o,
    output logic          pol_o,
    output logic          done_o,
    output logic [RW-1:0] count_o,
    output logic          ovr_o,
    output logic          zi_end_o
);

    localparam logic [CW-1:0] INT_LAST  = CW'(INT_CLKS - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(FULL_SCALE - 1);
    localparam logic [CW-1:0] ZIN_LAST  = CW'(ZI_NORM - 1);
    localparam logic [CW-1:0] ZIO_LAST  = CW'(ZI_OVER - 1);
    localparam logic [RW-1:0] FULL_CNT  = RW'(FULL_SCALE);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pol_q, pol_d;
    logic          ovr_q, ovr_d;
    logic          crossed;
    logic [CW-1:0] zi_last;

    assign crossed = (cmp_i != pol_q);
    assign zi_last = ovr_q ? ZIO_LAST : ZIN_LAST;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        pol_d    = pol_q;
        ovr_d    = ovr_q;
        done_o   = 1'b0;
        count_o  = '0;
        ovr_o    = 1'b0;
        zi_end_o = 1'b0;
        unique case (state_q)
            PH_AZ: begin
                if (cnt_q >= az_len_i - CW'(1)) begin
                    if (run_i) begin
                        state_d = PH_INT;
                        cnt_d   = '0;
                    end
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            PH_INT: begin
                if (cnt_q == INT_LAST) begin
                    state_d = PH_DE;
                    cnt_d   = '0;
                    pol_d   = cmp_i;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            PH_DE: begin
                if (crossed) begin
                    state_d = PH_ZI;
                    cnt_d   = '0;
                    ovr_d   = 1'b0;
                    done_o  = 1'b1;
                    count_o = RW'(cnt_q);
                end else if (cnt_q == FULL_LAST) begin
                    state_d = PH_ZI;
                    cnt_d   = '0;
                    ovr_d   = 1'b1;
                    done_o  = 1'b1;
                    count_o = FULL_CNT;
                    ovr_o   = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            PH_ZI: begin
                if (cnt_q == zi_last) begin
                    state_d  = PH_AZ;
                    cnt_d    = '0;
                    zi_end_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PH_AZ;
            cnt_q   <= '0;
            pol_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pol_q   <= pol_d;
            ovr_q   <= ovr_d;
        end
    end

    assign phase_o = state_q;
    assign pol_o   = pol_q;

    // R2
    phase_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != $past(state_q)) |-> (state_q == phase_succ($past(state_q))));

    // R3
    int_length_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PH_DE && $past(state_q) == PH_INT) |-> ($past(cnt_q) == INT_LAST));

    // R6
    de_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PH_DE) |-> (cnt_q <= FULL_LAST));

    // R10
    hold_az_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PH_AZ && !run_i) |=> (state_q == PH_AZ));

    // R4
    pol_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PH_DE && $past(state_q) == PH_DE) |-> $stable(pol_q));

endmodule

// File: rtl/dsq_cycle_fill.sv
module dsq_cycle_fill
    import dsq_pkg::*;
#(
    parameter int CYCLE_CLKS = 40000,
    parameter int AZ_MIN     = 100,
    parameter int CW         = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  phase_e        phase_i,
    input  logic          zi_end_i,
    output logic [CW-1:0] az_len_o
);

    localparam logic [CW:0]   CYC_W  = (CW+1)'(CYCLE_CLKS);
    localparam logic [CW:0]   MIN_W  = (CW+1)'(AZ_MIN);
    localparam logic [CW-1:0] MIN_AZ = CW'(AZ_MIN);

    logic [CW-1:0] elapsed_q;
    logic [CW-1:0] az_len_q;
    logic [CW:0]   used;
    logic [CW-1:0] fill;

    // clocks spent outside autozero, counting the current final ZI clock
    assign used = {1'b0, elapsed_q} + (CW+1)'(1);

    always_comb begin
        if (CYC_W >= used + MIN_W) begin
            fill = CW'(CYC_W - used);
        end else begin
            fill = MIN_AZ;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            elapsed_q <= '0;
            az_len_q  <= MIN_AZ;
        end else begin
            if (phase_i == PH_AZ) begin
                elapsed_q <= '0;
            end else begin
                elapsed_q <= elapsed_q + CW'(1);
            end
            if (zi_end_i) begin
                az_len_q <= fill;
            end
        end
    end

    assign az_len_o = az_len_q;

    // R9
    az_floor_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        zi_end_i |=> (az_len_o >= MIN_AZ));

endmodule

// File: rtl/dsq_result.sv
module dsq_result #(
    parameter int FULL_SCALE  = 20000,
    parameter int UNDER_LIMIT = 1800,
    parameter int RW          = 15
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          done_i,
    input  logic [RW-1:0] count_i,
    input  logic          pol_i,
    input  logic          ovr_i,
    output logic [RW-1:0] result_o,
    output logic          positive_o,
    output logic          over_o,
    output logic          under_o,
    output logic          strobe_o
);

    localparam logic [RW-1:0] UNDER_CNT = RW'(UNDER_LIMIT);
    localparam logic [RW-1:0] FULL_CNT  = RW'(FULL_SCALE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            result_o   <= '0;
            positive_o <= 1'b0;
            over_o     <= 1'b0;
            under_o    <= 1'b0;
            strobe_o   <= 1'b0;
        end else begin
            strobe_o <= done_i;
            if (done_i) begin
                result_o   <= count_i;
                positive_o <= pol_i;
                over_o     <= ovr_i;
                under_o    <= !ovr_i && (count_i < UNDER_CNT);
            end
        end
    end

    // R7
    flags_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(over_o && under_o));

    // R6
    over_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        over_o |-> (result_o == FULL_CNT));

    // R5
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
    import dsq_pkg::*;
#(
    parameter int INT_CLKS    = 10000,
    parameter int FULL_SCALE  = 20000,
    parameter int UNDER_LIMIT = 1800,
    parameter int AZ_MIN      = 100,
    parameter int ZI_NORM     = 150,
    parameter int ZI_OVER     = 6200,
    parameter int CYCLE_CLKS  = 40000,
    localparam int RW = $clog2(FULL_SCALE + 1),
    localparam int CW = $clog2(CYCLE_CLKS + INT_CLKS + FULL_SCALE + ZI_OVER + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic          cmp_i,
    output logic [3:0]    sel_o,
    output logic          busy_o,
    output logic          ref_pol_o,
    output logic [RW-1:0] result_o,
    output logic          positive_o,
    output logic          over_o,
    output logic          under_o,
    output logic          strobe_o
);

    phase_e        phase;
    logic          pol;
    logic          done;
    logic [RW-1:0] count;
    logic          ovr;
    logic          zi_end;
    logic [CW-1:0] az_len;

    dsq_phase_fsm #(
        .INT_CLKS  (INT_CLKS),
        .FULL_SCALE(FULL_SCALE),
        .ZI_NORM   (ZI_NORM),
        .ZI_OVER   (ZI_OVER),
        .CW        (CW),
        .RW        (RW)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (run_i),
        .cmp_i   (cmp_i),
        .az_len_i(az_len),
        .phase_o (phase),
        .pol_o   (pol),
        .done_o  (done),
        .count_o (count),
        .ovr_o   (ovr),
        .zi_end_o(zi_end)
    );

    dsq_cycle_fill #(
        .CYCLE_CLKS(CYCLE_CLKS),
        .AZ_MIN    (AZ_MIN),
        .CW        (CW)
    ) u_fill (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_i (phase),
        .zi_end_i(zi_end),
        .az_len_o(az_len)
    );

    dsq_result #(
        .FULL_SCALE (FULL_SCALE),
        .UNDER_LIMIT(UNDER_LIMIT),
        .RW         (RW)
    ) u_res (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .done_i    (done),
        .count_i   (count),
        .pol_i     (pol),
        .ovr_i     (ovr),
        .result_o  (result_o),
        .positive_o(positive_o),
        .over_o    (over_o),
        .under_o   (under_o),
        .strobe_o  (strobe_o)
    );

    always_comb begin
        unique case (phase)
            PH_AZ:  begin sel_o = 4'b0001; busy_o = 1'b0; end
            PH_INT: begin sel_o = 4'b0010; busy_o = 1'b1; end
            PH_DE:  begin sel_o = 4'b0100; busy_o = 1'b1; end
            PH_ZI:  begin sel_o = 4'b1000; busy_o = 1'b0; end
        endcase
    end

    assign ref_pol_o = pol;

    // R2
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(sel_o) == 1);

    // R5
    strobe_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |-> sel_o[3]);

    // R10
    hold_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_o[0] && $past(sel_o[0])) |-> $stable(result_o));

endmodule

// File: tb/dsq_seq_test.sv
module dsq_seq_test;

    localparam int INT_C  = 20;
    localparam int FULL_C = 40;
    localparam int UNDR_C = 5;
    localparam int AZMN_C = 3;
    localparam int ZIN_C  = 6;
    localparam int ZIO_C  = 25;
    localparam int CYC_C  = 80;
    localparam int RW     = $clog2(FULL_C + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b1;
    logic          cmp = 1'b0;
    logic [3:0]    sel;
    logic          busy, ref_pol, positive, over, under, strobe;
    logic [RW-1:0] result;

    int total = 0;
    int bad   = 0;
    int onehot_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dsq_seq #(
        .INT_CLKS   (INT_C),
        .FULL_SCALE (FULL_C),
        .UNDER_LIMIT(UNDR_C),
        .AZ_MIN     (AZMN_C),
        .ZI_NORM    (ZIN_C),
        .ZI_OVER    (ZIO_C),
        .CYCLE_CLKS (CYC_C)
    ) uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .run_i     (run),
        .cmp_i     (cmp),
        .sel_o     (sel),
        .busy_o    (busy),
        .ref_pol_o (ref_pol),
        .result_o  (result),
        .positive_o(positive),
        .over_o    (over),
        .under_o   (under),
        .strobe_o  (strobe)
    );

    // R2: one-hot select watched on every clock after reset
    always @(negedge clk) begin
        if (!rst && $countones(sel) != 1) onehot_err++;
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_az(input int de_clks, input int zi);
        int used = INT_C + de_clks + zi;
        return (CYC_C - used >= AZMN_C) ? CYC_C - used : AZMN_C;
    endfunction

    task automatic test_reset;
        int n = 0;
        rst = 1'b1;
        repeat (3) tick();
        check("R1 sel", int'(sel), 1);
        check("R1 result", int'(result), 0);
        check("R1 flags", int'({positive, over, under, strobe, busy}), 0);
        rst = 1'b0;
        while (sel[0] && n < 1000) begin n++; tick(); end
        check("R9 first autozero", n, AZMN_C);
    endtask

    // one conversion; k >= FULL_C means no crossing
    task automatic run_conv(input bit pol, input int k);
        int n = 0;
        int busy_bad = 0;
        int de_clks;
        int zi_exp;
        bit ovr_exp = (k >= FULL_C);
        int res_exp = ovr_exp ? FULL_C : k;
        while (!sel[1] && n < 1000) begin n++; tick(); end
        cmp = pol;
        n = 0;
        while (sel[1] && n < 1000) begin
            if (!busy) busy_bad++;
            n++;
            tick();
        end
        check("R3 integrate length", n, INT_C);
        check("R2 integrate then de-integrate", int'(sel), 4);
        check("R4 reference polarity", int'(ref_pol), int'(pol));
        if (ovr_exp) begin
            repeat (FULL_C) begin
                if (!busy) busy_bad++;
                tick();
            end
            de_clks = FULL_C;
        end else begin
            repeat (k) begin
                if (!busy) busy_bad++;
                tick();
            end
            cmp = ~pol;
            if (!busy) busy_bad++;
            tick();
            de_clks = k + 1;
        end
        check("R11 busy during measure", busy_bad, 0);
        check("R2 de-integrate then zero-integrator", int'(sel), 8);
        check("R5 strobe", int'(strobe), 1);
        check("R5/R6 result", int'(result), res_exp);
        check("R4 sign", int'(positive), int'(pol));
        check("R6 over", int'(over), int'(ovr_exp));
        check("R7 under", int'(under), int'(!ovr_exp && res_exp < UNDR_C));
        check("R11 busy low in discharge", int'(busy), 0);
        zi_exp = ovr_exp ? ZIO_C : ZIN_C;
        n = 1;
        tick();
        check("R5 strobe one clock", int'(strobe), 0);
        while (sel[3] && n < 1000) begin n++; tick(); end
        check("R8 zero-integrator length", n, zi_exp);
        check("R2 back to autozero", int'(sel), 1);
        n = 0;
        while (sel[0] && n < 1000) begin n++; tick(); end
        check("R9 autozero fill", n, exp_az(de_clks, zi_exp));
    endtask

    task automatic test_hold;
        int n = 0;
        int strobes = 0;
        int held = 0;
        while (!sel[1] && n < 1000) begin n++; tick(); end
        cmp = 1'b0;
        repeat (5) tick();
        run = 1'b0;
        n = 0;
        while (!sel[0] && n < 1000) begin
            if (sel[2] && n > 40) cmp = 1'b1;
            if (strobe) strobes++;
            n++;
            tick();
        end
        check("R10 cycle completes", strobes, 1);
        held = int'(result);
        strobes = 0;
        n = 0;
        repeat (150) begin
            if (!sel[0]) n++;
            if (strobe) strobes++;
            tick();
        end
        check("R10 parked in autozero", n, 0);
        check("R10 no strobe while parked", strobes, 0);
        check("R10 reading held", int'(result), held);
        check("R11 busy low while parked", int'(busy), 0);
        run = 1'b1;
        tick();
        check("R10 resume integrate", int'(sel), 2);
    endtask

    initial begin
        test_reset();
        run_conv(1'b1, 10);
        run_conv(1'b0, 2);
        run_conv(1'b1, UNDR_C);
        run_conv(1'b1, UNDR_C - 1);
        run_conv(1'b0, FULL_C);
        run_conv(1'b1, 0);
        run_conv(1'b0, FULL_C - 1);
        test_hold();
        check("R2 one-hot every clock", onehot_err, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule